// File: doc/BRIEF.md
# Flash Reset and Output-Disable Sequencer

This block handles the hardware reset pin and the output-enable pin of a parallel NOR-style flash controller. The reset pin is asynchronous, so it passes through a synchronizer and is then qualified. A low level counts as a reset only once it has been seen for a minimum number of consecutive clock cycles. A shorter glitch leaves the running operation alone.

A qualified reset does the following:
- It sends a one-cycle abort strobe to the command state machine, which terminates any program or erase and returns that machine to array-read mode.
- It withdraws command acceptance and the data-bus drive.
- It holds the ready/busy output low for a completion time. That time is longer when an embedded program or erase was running at the moment of qualification.

Once the completion time has run out and the pin is high again, ready/busy rises. Array reads and commands come back only after a further recovery period. The output-enable pin gates the data-bus drive at all times.

Top module: `flash_rst_seq`

## Requirements
- R1: After the system reset `rst_n` is released with the reset pin high, `cmd_en` is 1, `abort_p` is 0 and `ry_by_n` equals the inverse of `embed_busy`.
- R2: A low on `rst_pin_n` lasting fewer than T_RP clock cycles is ignored. No `abort_p` pulse occurs, `cmd_en` stays 1, and `ry_by_n` keeps following `embed_busy`.
- R3: A low lasting at least T_RP cycles is qualified at the clock edge SYNC_STAGES+T_RP cycles after the first low cycle. `abort_p` is high for exactly the one cycle that follows that edge.
- R4: From the qualification edge until recovery completes, `cmd_en` and `dq_oe` are 0, so commands are refused and the data bus is not driven.
- R5: If `embed_busy` is 1 at qualification, `ry_by_n` stays 0 for T_READY_EMB cycles, provided the pin is back high by then.
- R6: If `embed_busy` is 0 at qualification, `ry_by_n` stays 0 for T_READY_IDLE cycles, provided the pin is back high by then.
- R7: `ry_by_n` rises only when the completion time has expired and the synchronized pin is high. A pin held low past the completion time keeps it at 0.
- R8: `cmd_en` returns to 1 exactly T_RH cycles after `ry_by_n` rises. A short low on the pin during that window restarts the wait, which then ends T_RH cycles after the synchronized pin is seen high again.
- R9: A qualified reset during the recovery window produces a new `abort_p` pulse. It drives `ry_by_n` low again for the completion time.
- R10: `dq_oe` is 1 only when `oe_pin_n` is 0 and commands are accepted. `oe_pin_n` high forces `dq_oe` to 0 within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low |
| rst_pin_n | input | 1 | Asynchronous device reset pin, active low |
| oe_pin_n | input | 1 | Output-enable pin, active low |
| embed_busy | input | 1 | High while an embedded program or erase runs |
| ry_by_n | output | 1 | Ready (1) / busy (0) |
| dq_oe | output | 1 | Data-bus drive enable |
| cmd_en | output | 1 | Read and write commands accepted |
| abort_p | output | 1 | One-cycle abort and return-to-read strobe |

## Verification
Every pin event is referred to the cycle `k0` at which the bench starts it. This gives the following due cycles:
- The abort strobe is due at `k0`+SYNC_STAGES+T_RP.
- The rising edge of ready/busy is due at `X = k0 + max(SYNC_STAGES+T_RP+T_READY, SYNC_STAGES+L+1)` for a pulse of L cycles.
- Command acceptance is due at X+T_RH.

The driver pushes the expected levels for the cycles just before and at each of these edges into a scoreboard queue. The monitor pops each entry at the falling clock edge whose cycle count matches, so that every transition is pinned to its exact cycle. `dq_oe` is combinational on `oe_pin_n`, so it is checked one time step after the pin moves.

// File: rtl/frs_pkg.sv
package frs_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HALT  = 2'd1,
      ST_RECOV = 2'd2
   } frs_state_e;

   function automatic int unsigned frs_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else if (STAGES == 1) sh <= d;
            else sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/frs_qual.sv
module frs_qual #(
   parameter int unsigned T_RP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_low,
   output logic qual
);
   localparam int unsigned QW = (T_RP > 1) ? $clog2(T_RP) : 1;
   localparam logic [QW-1:0] QLAST = QW'(T_RP - 1);

   logic [QW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= '0;
      else if (!pin_low) run_len <= '0;
      else if (run_len != QLAST) run_len <= run_len + 1'b1;
   end

   assign qual = pin_low && (run_len == QLAST);
endmodule

// File: rtl/frs_timer.sv
module frs_timer #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec && (cnt != '0)) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
   import frs_pkg::*;
#(
   parameter int unsigned W            = 6,
   parameter int unsigned T_READY_EMB  = 40,
   parameter int unsigned T_READY_IDLE = 10,
   parameter int unsigned T_RH         = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pin_hi,
   input  logic         qual,
   input  logic         embed_busy,
   input  logic         rdy_zero,
   input  logic         rh_zero,
   output logic         rdy_load,
   output logic [W-1:0] rdy_val,
   output logic         rdy_dec,
   output logic         rh_load,
   output logic [W-1:0] rh_val,
   output logic         rh_dec,
   output frs_state_e   state,
   output logic         abort_p
);
   localparam logic [W-1:0] EMB_LD  = W'(T_READY_EMB - 1);
   localparam logic [W-1:0] IDLE_LD = W'(T_READY_IDLE - 1);
   localparam logic [W-1:0] RH_LD   = W'(T_RH - 1);

   frs_state_e nxt;
   logic       take;

   // a qualified reset is acted on outside the halt state only
   assign take = qual && (state != ST_HALT);

   always_comb begin
      nxt      = state;
      rdy_load = 1'b0;
      rdy_dec  = 1'b0;
      rh_load  = 1'b0;
      rh_dec   = 1'b0;
      rdy_val  = embed_busy ? EMB_LD : IDLE_LD;
      rh_val   = RH_LD;
      unique case (state)
         ST_RUN: begin
            if (take) begin
               nxt      = ST_HALT;
               rdy_load = 1'b1;
            end
         end
         ST_HALT: begin
            if (rdy_zero && pin_hi) begin
               nxt     = ST_RECOV;
               rh_load = 1'b1;
            end else begin
               rdy_dec = 1'b1;
            end
         end
         ST_RECOV: begin
            if (take) begin
               nxt      = ST_HALT;
               rdy_load = 1'b1;
            end else if (!pin_hi) begin
               rh_load = 1'b1;
            end else if (rh_zero) begin
               nxt = ST_RUN;
            end else begin
               rh_dec = 1'b1;
            end
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_RUN;
         abort_p <= 1'b0;
      end else begin
         state   <= nxt;
         abort_p <= take;
      end
   end
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
   import frs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned T_RP         = 8,
   parameter int unsigned T_READY_EMB  = 40,
   parameter int unsigned T_READY_IDLE = 10,
   parameter int unsigned T_RH         = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_pin_n,
   input  logic oe_pin_n,
   input  logic embed_busy,
   output logic ry_by_n,
   output logic dq_oe,
   output logic cmd_en,
   output logic abort_p
);
   localparam int unsigned TMAX = frs_max(frs_max(T_READY_EMB, T_READY_IDLE), T_RH);
   localparam int unsigned TW   = $clog2(TMAX + 1);

   generate
      if (T_RP < 1) begin : g_bad_rp
         $error("T_RP must be at least 1");
      end
      if (T_READY_IDLE < 2 || T_READY_EMB < 2) begin : g_bad_ready
         $error("completion times must be at least 2");
      end
      if (T_RH < 1) begin : g_bad_rh
         $error("T_RH must be at least 1");
      end
   endgenerate

   logic       pin_s;
   logic       qual;
   logic       rdy_load, rdy_dec, rdy_zero;
   logic       rh_load, rh_dec, rh_zero;
   logic [TW-1:0] rdy_val, rh_val;
   frs_state_e state;

   frs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rst_pin_n), .q(pin_s)
   );

   frs_qual #(.T_RP(T_RP)) u_qual (
      .clk(clk), .rst_n(rst_n), .pin_low(!pin_s), .qual(qual)
   );

   frs_timer #(.W(TW)) u_rdy_tmr (
      .clk(clk), .rst_n(rst_n), .load(rdy_load), .load_val(rdy_val),
      .dec(rdy_dec), .zero(rdy_zero)
   );

   frs_timer #(.W(TW)) u_rh_tmr (
      .clk(clk), .rst_n(rst_n), .load(rh_load), .load_val(rh_val),
      .dec(rh_dec), .zero(rh_zero)
   );

   frs_ctrl #(
      .W(TW), .T_READY_EMB(T_READY_EMB), .T_READY_IDLE(T_READY_IDLE), .T_RH(T_RH)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_hi(pin_s), .qual(qual),
      .embed_busy(embed_busy), .rdy_zero(rdy_zero), .rh_zero(rh_zero),
      .rdy_load(rdy_load), .rdy_val(rdy_val), .rdy_dec(rdy_dec),
      .rh_load(rh_load), .rh_val(rh_val), .rh_dec(rh_dec),
      .state(state), .abort_p(abort_p)
   );

   assign cmd_en  = (state == ST_RUN);
   assign ry_by_n = (state == ST_RUN) ? !embed_busy : (state == ST_RECOV);
   assign dq_oe   = cmd_en && !oe_pin_n;
endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic oe_pin_n,
   input logic ry_by_n,
   input logic dq_oe,
   input logic cmd_en,
   input logic abort_p
);
   // R3
   abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p |=> !abort_p);

   // R4
   abort_blocks_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p |-> !cmd_en);

   // R4
   cmd_stop_needs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_en) |-> abort_p);

   // R5
   busy_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p |-> !ry_by_n);

   // R8
   ready_before_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_en) |-> $past(ry_by_n));

   // R10
   oe_high_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_pin_n |-> !dq_oe);
endmodule

bind flash_rst_seq flash_rst_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .oe_pin_n(oe_pin_n), .ry_by_n(ry_by_n),
   .dq_oe(dq_oe), .cmd_en(cmd_en), .abort_p(abort_p)
);

// File: tb/flash_rst_seq_tb.sv
`timescale 1ns/1ps
module flash_rst_seq_tb;
   localparam int S     = 2;
   localparam int TRP   = 8;
   localparam int TEMB  = 40;
   localparam int TIDLE = 10;
   localparam int TRH   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_pin_n = 1'b1;
   logic oe_pin_n = 1'b1;
   logic embed_busy = 1'b0;
   logic ry_by_n, dq_oe, cmd_en, abort_p;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int n_abort = 0;

   typedef struct {
      int    cyc;
      string req;
      int    ry;
      int    cmd;
      int    ab;
   } item_t;

   item_t sb[$];

   flash_rst_seq #(
      .SYNC_STAGES(S), .T_RP(TRP), .T_READY_EMB(TEMB),
      .T_READY_IDLE(TIDLE), .T_RH(TRH)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .oe_pin_n(oe_pin_n),
      .embed_busy(embed_busy), .ry_by_n(ry_by_n), .dq_oe(dq_oe),
      .cmd_en(cmd_en), .abort_p(abort_p)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string r, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: got %0d expected %0d", r, what, cyc, act, exp);
      end
   endtask

   function automatic void expect_at(input int c, input string r, input int ry, input int cmd, input int ab);
      item_t it;
      it.cyc = c; it.req = r; it.ry = ry; it.cmd = cmd; it.ab = ab;
      sb.push_back(it);
   endfunction

   // monitor: pops expected items at the matching falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (abort_p) n_abort++;
         while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.cyc < cyc) chk(it.req, "missed slot", it.cyc, cyc);
            if (it.ry >= 0) chk(it.req, "ry_by_n", int'(ry_by_n), it.ry);
            if (it.cmd >= 0) begin
               chk(it.req, "cmd_en", int'(cmd_en), it.cmd);
               chk(it.req, "dq_oe", int'(dq_oe), it.cmd);
            end
            if (it.ab >= 0) chk(it.req, "abort_p", int'(abort_p), it.ab);
         end
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
      #1;
   endtask

   // qualified reset pulse of L cycles; returns cycle of ry_by_n rise
   task automatic rst_pulse(input int L, input bit busy, input bit chain,
                            input bit in_recov, input string rr, output int x_out);
      int k0, q, t, x;
      k0 = cyc;
      embed_busy = busy;
      t = busy ? TEMB : TIDLE;
      q = k0 + S + TRP;
      x = k0 + (((S + TRP + t) > (S + L + 1)) ? (S + TRP + t) : (S + L + 1));
      if (in_recov) expect_at(q - 1, "R9", 1, 0, 0);
      else expect_at(q - 1, "R3", busy ? 0 : 1, 1, 0);
      expect_at(q, "R3", 0, 0, 1);
      expect_at(q + 1, "R3", 0, 0, 0);
      expect_at(x - 1, rr, 0, 0, -1);
      expect_at(x, rr, 1, 0, -1);
      if (!chain) begin
         expect_at(x + TRH - 1, "R8", 1, 0, 0);
         expect_at(x + TRH, "R8", 1, 1, 0);
      end
      rst_pin_n = 1'b0;
      repeat (L) @(posedge clk);
      tick();
      rst_pin_n = 1'b1;
      wait_until(x);
      embed_busy = 1'b0;
      if (!chain) wait_until(x + TRH + 1);
      x_out = x;
   endtask

   initial begin
      int x, n0, k0;
      repeat (3) @(posedge clk);
      tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "cmd_en", int'(cmd_en), 1);
      chk("R1", "abort_p", int'(abort_p), 0);
      chk("R1", "ry_by_n idle", int'(ry_by_n), 1);
      embed_busy = 1'b1; #1;
      chk("R1", "ry_by_n busy", int'(ry_by_n), 0);
      embed_busy = 1'b0;
      // R10 output enable gating
      chk("R10", "dq_oe oe high", int'(dq_oe), 0);
      oe_pin_n = 1'b0; #1;
      chk("R10", "dq_oe oe low", int'(dq_oe), 1);
      oe_pin_n = 1'b1; #1;
      chk("R10", "dq_oe oe back high", int'(dq_oe), 0);
      oe_pin_n = 1'b0;
      tick();
      // R2 short glitch during a program: ignored
      embed_busy = 1'b1;
      n0 = n_abort;
      rst_pin_n = 1'b0;
      repeat (TRP - 1) @(posedge clk);
      tick();
      rst_pin_n = 1'b1;
      repeat (S + 4) tick();
      chk("R2", "abort count", n_abort, n0);
      chk("R2", "cmd_en", int'(cmd_en), 1);
      chk("R2", "ry_by_n", int'(ry_by_n), 0);
      embed_busy = 1'b0;
      tick();
      // R5 embedded reset, minimum width
      rst_pulse(TRP, 1'b1, 1'b0, 1'b0, "R5", x);
      // R6/R7 idle reset, pin held past completion time
      rst_pulse(25, 1'b0, 1'b0, 1'b0, "R7", x);
      // R6 idle reset, then a glitch inside recovery (R8)
      rst_pulse(TRP, 1'b0, 1'b1, 1'b0, "R6", x);
      n0 = n_abort;
      k0 = cyc;
      expect_at(k0 + S + 3 + TRH - 1, "R8", 1, 0, 0);
      expect_at(k0 + S + 3 + TRH, "R8", 1, 1, 0);
      rst_pin_n = 1'b0;
      repeat (3) @(posedge clk);
      tick();
      rst_pin_n = 1'b1;
      wait_until(k0 + S + 3 + TRH + 1);
      chk("R8", "no abort on glitch", n_abort, n0);
      // R9 qualified reset inside recovery
      rst_pulse(TRP, 1'b0, 1'b1, 1'b0, "R6", x);
      rst_pulse(TRP, 1'b0, 1'b0, 1'b1, "R9", x);
      repeat (3) tick();
      chk("R4", "scoreboard drained", sb.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule